// File: doc/BRIEF.md
# Type-Filtered Set-Associative Lookup

This unit performs the tag check and data read of a set-associative cache. Next to its tag and data, every line also holds one bit saying whether the block is private to one core or shared between several. A request brings a set index, a tag and the kind bit that the address translation step has already produced. Only ways whose line is valid and whose stored kind equals the request's kind are enabled. Only those ways take part in the tag compare and the data selection. The other ways, including every invalid way, stay dark. The per-way enable vector leaves the unit as a stand-in for divided wordlines. A per-access enable count and a running total of enabled ways let the saving be measured.

Requests that come from the coherence network are always looked up as shared, whatever kind bit they carry. A miss reports the kind the lookup used, so that the refill from the next level can store that same kind. A separate retype command promotes a matching line to shared when its page changes from private to shared. Line allocation is driven from outside through a fill port that names the way. The unit has no replacement policy.

Top module: `tfl_lookup_unit`

## Requirements
- R1: After synchronous active-low reset, every line is invalid, rsp_valid is 0, en_total is 0, and a lookup into any set reports a miss with way_en all zero and en_count 0.
- R2: One cycle after a cycle with req_valid high, rsp_valid is 1 and way_en bit w is 1 exactly when way w of the addressed set is valid and its stored kind equals the lookup kind. In a cycle after one without a request, rsp_valid, way_en and en_count are all 0.
- R3: en_count equals the number of ones in way_en.
- R4: rsp_hit is 1 when an enabled way holds the request tag. rsp_way then gives that way's binary index, picking the lowest index if several ways match, and rsp_data gives that way's data. On a miss, rsp_way and rsp_data are 0.
- R5: A tag held only in a way of the other kind, or only in an invalid way, gives a miss.
- R6: With req_net at 1, the lookup kind is shared (1) no matter what req_kind is. With req_net at 0, the lookup kind is req_kind (0 private, 1 shared).
- R7: rsp_fwd_kind reports the lookup kind of the request that produced the response. A fill stores fill_kind with the line, and a later lookup of that kind and tag hits.
- R8: A retype command sets the stored kind of every valid way in retype_index whose tag equals retype_tag to shared. If no way matches, nothing changes.
- R9: en_total grows by the en_count of each response, modulo 2^TOTAL_W, in the same cycle that the response appears.
- R10: A lookup sees the set contents from before any fill or retype issued in the same cycle. When a fill and a retype hit the same line in one cycle, the fill's kind is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_net | input | 1 | Request comes from the coherence network |
| req_kind | input | 1 | Kind from translation: 0 private, 1 shared |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Tag to compare |
| fill_valid | input | 1 | Write a line |
| fill_index | input | IDX_W | Set to fill |
| fill_way | input | WAY_W | Way to fill |
| fill_kind | input | 1 | Kind stored with the filled line |
| fill_tag | input | TAG_W | Tag of the filled line |
| fill_data | input | DATA_W | Data of the filled line |
| retype_valid | input | 1 | Promote matching line to shared |
| retype_index | input | IDX_W | Set to search for retype |
| retype_tag | input | TAG_W | Tag to search for retype |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hit way index |
| rsp_data | output | DATA_W | Hit data |
| rsp_fwd_kind | output | 1 | Kind used by the lookup, to be carried by a miss |
| way_en | output | WAYS | Per-way enable, one bit per way |
| en_count | output | CNT_W | Number of ways enabled for this response |
| en_total | output | TOTAL_W | Running sum of en_count |

## Verification
The hardest cases to reach from the ports are the collisions. One is a tag that sits in a way of the other kind only. Another is a pair of ways of the same kind holding one tag. The last is a fill and a retype landing on the same line in the same cycle while a lookup reads that set. Directed phases first build each of these on purpose: duplicate tags across kinds and within one kind, a retype issued together with a refill of a matching way, and a lookup issued together with a fill. A long random phase then restricts traffic to two sets and four tags, so that such collisions keep recurring. A behavioural model of the line contents predicts every output on every cycle.

// File: rtl/tfl_pkg.sv
// Shared types for the type-filtered lookup unit.
// Assumes: one kind bit per line, 0 = private, 1 = shared.
package tfl_pkg;
    typedef enum logic {
        KIND_PRIVATE = 1'b0,
        KIND_SHARED  = 1'b1
    } blk_kind_e;
endpackage

// File: rtl/tfl_line_store.sv
// Per-way line storage: valid, kind, tag and data for every set.
// Each way keeps its own arrays, generated once per way.
// Assumes: fill names its way; retype promotes matching valid lines to shared;
// when fill and retype land on the same line, the fill wins; reads are combinational.
module tfl_line_store
    import tfl_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int SETS   = 16,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_index,
    output logic [WAYS-1:0]         rd_valid,
    output logic [WAYS-1:0]         rd_kind,
    output logic [WAYS*TAG_W-1:0]   rd_tag,
    output logic [WAYS*DATA_W-1:0]  rd_data,
    input  logic                    fill_valid,
    input  logic [IDX_W-1:0]        fill_index,
    input  logic [WAY_W-1:0]        fill_way,
    input  logic                    fill_kind,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic                    retype_valid,
    input  logic [IDX_W-1:0]        retype_index,
    input  logic [TAG_W-1:0]        retype_tag
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   valid_q;
        logic [SETS-1:0]   kind_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS];
        logic              fill_here;
        logic              retype_here;

        // Decode whether this way is written by fill or matched by retype.
        always_comb begin
            fill_here   = fill_valid && (fill_way == WAY_W'(w));
            retype_here = retype_valid && valid_q[retype_index] &&
                          (tag_q[retype_index] == retype_tag);
        end

        // Valid and kind bits; fill assignment placed last so it wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                kind_q  <= '0;
            end else begin
                if (retype_here)
                    kind_q[retype_index] <= KIND_SHARED;
                if (fill_here) begin
                    valid_q[fill_index] <= 1'b1;
                    kind_q[fill_index]  <= fill_kind;
                end
            end
        end

        // Tag and data arrays need no reset; valid guards them.
        always_ff @(posedge clk) begin
            if (fill_here) begin
                tag_q[fill_index]  <= fill_tag;
                data_q[fill_index] <= fill_data;
            end
        end

        // Present the addressed set of this way.
        always_comb begin
            rd_valid[w]                    = valid_q[rd_index];
            rd_kind[w]                     = kind_q[rd_index];
            rd_tag[w*TAG_W +: TAG_W]       = tag_q[rd_index];
            rd_data[w*DATA_W +: DATA_W]    = data_q[rd_index];
        end
    end
endmodule

// File: rtl/tfl_way_filter.sv
// Wordline filter: enables a way only when it is valid and its kind matches.
// Only enabled ways take part in the tag compare.
// Assumes: lookup kind already resolved (network requests forced to shared).
module tfl_way_filter #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 10
) (
    input  logic                  req_valid,
    input  logic                  look_kind,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [WAYS-1:0]       rd_valid,
    input  logic [WAYS-1:0]       rd_kind,
    input  logic [WAYS*TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]       way_en,
    output logic [WAYS-1:0]       tag_hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        // Enable the way, then compare its tag only when enabled.
        always_comb begin
            way_en[w]  = req_valid && rd_valid[w] && (rd_kind[w] == look_kind);
            tag_hit[w] = way_en[w] && (rd_tag[w*TAG_W +: TAG_W] == req_tag);
        end
    end
endmodule

// File: rtl/tfl_hit_select.sv
// Hit resolution: lowest matching way wins, data mux over enabled ways only,
// and a population count of the enabled ways.
// Assumes: tag_hit is a subset of way_en.
module tfl_hit_select #(
    parameter int WAYS   = 8,
    parameter int DATA_W = 32,
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(WAYS + 1)
) (
    input  logic [WAYS-1:0]        way_en,
    input  logic [WAYS-1:0]        tag_hit,
    input  logic [WAYS*DATA_W-1:0] rd_data,
    output logic                   hit,
    output logic [WAY_W-1:0]       hit_way,
    output logic [DATA_W-1:0]      hit_data,
    output logic [CNT_W-1:0]       en_count
);
    logic [DATA_W-1:0] gated [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_gate
        // Data of a disabled way never reaches the mux.
        always_comb gated[w] = way_en[w] ? rd_data[w*DATA_W +: DATA_W] : '0;
    end

    // Priority select: scan downward so the lowest hit index remains.
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        hit_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (tag_hit[w]) begin
                hit      = 1'b1;
                hit_way  = WAY_W'(w);
                hit_data = gated[w];
            end
        end
    end

    // Count enabled ways.
    always_comb begin
        en_count = '0;
        for (int w = 0; w < WAYS; w++)
            en_count = en_count + CNT_W'(way_en[w]);
    end
endmodule

// File: rtl/tfl_lookup_unit.sv
// Top of the type-filtered lookup: resolves the lookup kind, reads the set,
// filters ways by kind and validity, selects the hit and registers the result.
// Assumes: one request per cycle, response one cycle later; fill and retype
// in the same cycle take effect after that cycle's lookup has read the set.
module tfl_lookup_unit
    import tfl_pkg::*;
#(
    parameter int WAYS    = 8,
    parameter int SETS    = 16,
    parameter int TAG_W   = 10,
    parameter int DATA_W  = 32,
    parameter int TOTAL_W = 24,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CNT_W  = $clog2(WAYS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_net,
    input  logic               req_kind,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_index,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic               fill_kind,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               retype_valid,
    input  logic [IDX_W-1:0]   retype_index,
    input  logic [TAG_W-1:0]   retype_tag,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WAY_W-1:0]   rsp_way,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_fwd_kind,
    output logic [WAYS-1:0]    way_en,
    output logic [CNT_W-1:0]   en_count,
    output logic [TOTAL_W-1:0] en_total
);
    logic                  look_kind;
    logic [WAYS-1:0]       rd_valid;
    logic [WAYS-1:0]       rd_kind;
    logic [WAYS*TAG_W-1:0] rd_tag;
    logic [WAYS*DATA_W-1:0] rd_data;
    logic [WAYS-1:0]       en_c;
    logic [WAYS-1:0]       hit_vec;
    logic                  hit_c;
    logic [WAY_W-1:0]      way_c;
    logic [DATA_W-1:0]     data_c;
    logic [CNT_W-1:0]      cnt_c;

    // Network probes always look among shared lines.
    always_comb look_kind = req_net ? KIND_SHARED : req_kind;

    tfl_line_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_index(req_index),
        .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_tag(rd_tag), .rd_data(rd_data),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_way(fill_way),
        .fill_kind(fill_kind), .fill_tag(fill_tag), .fill_data(fill_data),
        .retype_valid(retype_valid), .retype_index(retype_index), .retype_tag(retype_tag)
    );

    tfl_way_filter #(.WAYS(WAYS), .TAG_W(TAG_W)) u_filter (
        .req_valid(req_valid), .look_kind(look_kind), .req_tag(req_tag),
        .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_tag(rd_tag),
        .way_en(en_c), .tag_hit(hit_vec)
    );

    tfl_hit_select #(.WAYS(WAYS), .DATA_W(DATA_W)) u_select (
        .way_en(en_c), .tag_hit(hit_vec), .rd_data(rd_data),
        .hit(hit_c), .hit_way(way_c), .hit_data(data_c), .en_count(cnt_c)
    );

    // Response register and enable accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_way      <= '0;
            rsp_data     <= '0;
            rsp_fwd_kind <= 1'b0;
            way_en       <= '0;
            en_count     <= '0;
            en_total     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_hit      <= hit_c;
                rsp_way      <= hit_c ? way_c : '0;
                rsp_data     <= hit_c ? data_c : '0;
                rsp_fwd_kind <= look_kind;
                way_en       <= en_c;
                en_count     <= cnt_c;
                en_total     <= en_total + TOTAL_W'(cnt_c);
            end else begin
                rsp_hit  <= 1'b0;
                rsp_way  <= '0;
                rsp_data <= '0;
                way_en   <= '0;
                en_count <= '0;
            end
        end
    end
endmodule

// File: rtl/tfl_lookup_chk.sv
// Property checker for tfl_lookup_unit, attached by bind below.
// Assumes: synchronous active-low reset held from time zero.
module tfl_lookup_chk #(
    parameter int WAYS    = 8,
    parameter int TOTAL_W = 24,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int CNT_W  = $clog2(WAYS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_net,
    input logic               req_kind,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [WAY_W-1:0]   rsp_way,
    input logic               rsp_fwd_kind,
    input logic [WAYS-1:0]    way_en,
    input logic [CNT_W-1:0]   en_count,
    input logic [TOTAL_W-1:0] en_total
);
    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    assert_idle_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (way_en == '0 && en_count == '0 && !rsp_hit));

    assert_count_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_count == CNT_W'($countones(way_en)));

    assert_hit_in_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> way_en[rsp_way]);

    assert_net_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fwd_kind == ($past(req_net) | $past(req_kind)));

    assert_total_accum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_total == $past(en_total) + TOTAL_W'(en_count));
endmodule

bind tfl_lookup_unit tfl_lookup_chk #(.WAYS(WAYS), .TOTAL_W(TOTAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_net(req_net),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_fwd_kind(rsp_fwd_kind), .way_en(way_en),
    .en_count(en_count), .en_total(en_total)
);

// File: tb/sim_tfl_lookup_unit.sv
`timescale 1ns/1ps
// Bench: behavioural line model predicts every output, compared each clock.
module sim_tfl_lookup_unit;
    localparam int WAYS = 8, SETS = 16, TAG_W = 10, DATA_W = 32, TOTAL_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               req_valid = 0, req_net = 0, req_kind = 0;
    logic [3:0]         req_index = 0;
    logic [TAG_W-1:0]   req_tag = 0;
    logic               fill_valid = 0, fill_kind = 0;
    logic [3:0]         fill_index = 0;
    logic [2:0]         fill_way = 0;
    logic [TAG_W-1:0]   fill_tag = 0;
    logic [DATA_W-1:0]  fill_data = 0;
    logic               retype_valid = 0;
    logic [3:0]         retype_index = 0;
    logic [TAG_W-1:0]   retype_tag = 0;
    logic               rsp_valid, rsp_hit, rsp_fwd_kind;
    logic [2:0]         rsp_way;
    logic [DATA_W-1:0]  rsp_data;
    logic [WAYS-1:0]    way_en;
    logic [3:0]         en_count;
    logic [TOTAL_W-1:0] en_total;

    tfl_lookup_unit u0 (.*);

    // Model of line contents.
    bit          mv [SETS][WAYS];
    bit          mk [SETS][WAYS];
    int          mt [SETS][WAYS];
    int unsigned md [SETS][WAYS];

    // Next-cycle stimulus.
    bit nq, nn, nk, nf, nfk, nr;
    int ni, ntag, nfi, nfw, nft, nri, nrt;
    int unsigned nfd;

    // Expected outputs.
    bit e_valid, e_hit, e_fwd;
    int e_way, e_cnt;
    int unsigned e_data, e_total;
    bit [WAYS-1:0] e_en;
    string phase = "R1";

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic clear_nx();
        nq = 0; nn = 0; nk = 0; nf = 0; nfk = 0; nr = 0;
        ni = 0; ntag = 0; nfi = 0; nfw = 0; nft = 0; nri = 0; nrt = 0; nfd = 0;
    endtask

    // One clock: compare outputs, predict the next response, update model, drive.
    task automatic tick();
        bit eff;
        bit [WAYS-1:0] rm;
        @(negedge clk);
        chk("R2", "rsp_valid", rsp_valid, e_valid);
        chk("R2", "way_en", way_en, e_en);
        chk("R3", "en_count", en_count, e_cnt);
        chk("R9", "en_total", en_total, e_total);
        chk(phase, "rsp_hit", rsp_hit, e_hit);
        chk("R4", "rsp_way", rsp_way, e_way);
        chk("R4", "rsp_data", rsp_data, e_data);
        if (e_valid) chk("R7", "rsp_fwd_kind", rsp_fwd_kind, e_fwd);
        eff = nn | nk;
        e_valid = nq; e_en = '0; e_cnt = 0; e_hit = 0; e_way = 0; e_data = 0;
        if (nq) begin
            e_fwd = eff;
            for (int w = 0; w < WAYS; w++)
                if (mv[ni][w] && mk[ni][w] == eff) begin
                    e_en[w] = 1; e_cnt++;
                    if (!e_hit && mt[ni][w] == ntag) begin
                        e_hit = 1; e_way = w; e_data = md[ni][w];
                    end
                end
            e_total = (e_total + e_cnt) % (1 << TOTAL_W);
        end
        rm = '0;
        if (nr) for (int w = 0; w < WAYS; w++) rm[w] = mv[nri][w] && mt[nri][w] == nrt;
        for (int w = 0; w < WAYS; w++) if (rm[w]) mk[nri][w] = 1;
        if (nf) begin
            mv[nfi][nfw] = 1; mk[nfi][nfw] = nfk; mt[nfi][nfw] = nft; md[nfi][nfw] = nfd;
        end
        req_valid = nq; req_net = nn; req_kind = nk; req_index = 4'(ni); req_tag = TAG_W'(ntag);
        fill_valid = nf; fill_index = 4'(nfi); fill_way = 3'(nfw); fill_kind = nfk;
        fill_tag = TAG_W'(nft); fill_data = nfd;
        retype_valid = nr; retype_index = 4'(nri); retype_tag = TAG_W'(nrt);
        clear_nx();
    endtask

    task automatic look(int i, int t, bit k, bit net);
        nq = 1; ni = i; ntag = t; nk = k; nn = net; tick();
    endtask

    task automatic fill(int i, int w, int t, bit k, int unsigned d);
        nf = 1; nfi = i; nfw = w; nft = t; nfk = k; nfd = d; tick();
    endtask

    task automatic retype(int i, int t);
        nr = 1; nri = i; nrt = t; tick();
    endtask

    initial begin
        clear_nx();
        e_valid = 0; e_en = 0; e_cnt = 0; e_hit = 0; e_way = 0; e_data = 0; e_total = 0; e_fwd = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: empty cache after reset.
        phase = "R1";
        tick();
        for (int i = 0; i < 4; i++) look(i * 5 % SETS, 3, i[0], i[1]);
        tick();
        // R4/R5: set 3 with mixed kinds, way 7 left invalid.
        phase = "R4";
        for (int w = 0; w < 7; w++) fill(3, w, 'h10 + w, bit'(w % 2), 32'hA000 + w);
        fill(3, 6, 'h12, 1, 32'hBEEF);
        phase = "R5";
        for (int t = 'h10; t < 'h18; t++) begin
            look(3, t, 0, 0);
            look(3, t, 1, 0);
        end
        // R6: network probes with private kind still look among shared ways.
        phase = "R6";
        for (int t = 'h10; t < 'h18; t++) look(3, t, 0, 1);
        // R4: two private ways with one tag, lowest index wins.
        phase = "R4";
        fill(9, 4, 'h33, 0, 32'h4444);
        fill(9, 1, 'h33, 0, 32'h1111);
        look(9, 'h33, 0, 0);
        // R10: fill and lookup together; fill and retype on the same line.
        phase = "R10";
        nq = 1; ni = 3; ntag = 'h40; nk = 1; nf = 1; nfi = 3; nfw = 7; nft = 'h40; nfk = 1; nfd = 32'h7777; tick();
        look(3, 'h40, 1, 0);
        nr = 1; nri = 9; nrt = 'h33; nf = 1; nfi = 9; nfw = 1; nft = 'h50; nfk = 0; nfd = 32'h5050; tick();
        look(9, 'h33, 0, 0);
        look(9, 'h33, 1, 0);
        look(9, 'h50, 0, 0);
        // R8: promote private way 0, then retype a missing tag.
        phase = "R8";
        retype(3, 'h10);
        look(3, 'h10, 0, 0);
        look(3, 'h10, 1, 0);
        retype(3, 'h3FF);
        look(3, 'h11, 1, 0);
        look(3, 'h14, 0, 0);
        // R7: a miss reports its kind; the refill keeps it.
        phase = "R7";
        look(12, 'h77, 0, 0);
        fill(12, 2, 'h77, 0, 32'hC0DE);
        look(12, 'h77, 0, 0);
        look(12, 'h77, 0, 1);
        // Random traffic on two sets and four tags.
        phase = "R5";
        for (int n = 0; n < 4000; n++) begin
            nq = $urandom_range(0, 3) != 0;
            ni = $urandom_range(0, 1); ntag = $urandom_range(0, 3);
            nk = 1'($urandom); nn = $urandom_range(0, 4) == 0;
            nf = $urandom_range(0, 2) == 0;
            nfi = $urandom_range(0, 1); nfw = $urandom_range(0, WAYS - 1);
            nft = $urandom_range(0, 3); nfk = 1'($urandom); nfd = $urandom;
            nr = $urandom_range(0, 5) == 0;
            nri = $urandom_range(0, 1); nrt = $urandom_range(0, 3);
            tick();
        end
        tick();
        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule